// File: doc/BRIEF.md
# Multiple Header Error Log Queue

This block keeps the header record of uncorrectable errors for one function. When an error record arrives it either loads the record into the visible log registers or, when a still-unserviced error already owns those registers, parks it in a small first-in first-out store. The visible state has three parts: a first-error pointer that gives the bit index of the logged error, a four-word header log, and a four-word prefix log with a valid flag. Each word is held byte-reversed, so software that reads the register file little-endian sees the words in network byte order.

The block does not own the uncorrectable status register. It samples that register's current value on `unc_status`. Software writes to that register are signalled on `sw_wr`, with `unc_status` already showing the value after the write. The block answers with a one-cycle `status_reassert` mask, which the register file ORs back into the status bits. This is how queued errors stay visible after software clears them. When software clears the bit the pointer names, the next queued record moves into the log. A record that finds the store full is dropped, and `log_ovf` pulses.

Top module: `hdrq_log_queue`

## Requirements
- R1: On a record accepted into the log, `fep` becomes the index of the lowest set bit of `rec_status`.
- R2: A loaded header word i appears on `hdr_log[32*i+31:32*i]` with its four bytes in reverse order (bits 7:0 move to 31:24, and so on); the whole header log is zero when `rec_hdr_vld` was low.
- R3: The prefix log is loaded byte-reversed like the header, and `pfx_flag` is set, only when the record has `rec_pfx_vld` high and `pfx_en` is high at load time; otherwise the prefix log and `pfx_flag` are zero.
- R4: With `mhr_en` high and `unc_status[fep]` set, a new record is queued and `fep` and both logs keep their values.
- R5: A record that must be queued while the store holds DEPTH entries and nothing is popped is dropped, and `log_ovf` is high for exactly the one cycle after it.
- R6: A write (`sw_wr`) whose `unc_status[fep]` is clear, with `mhr_en` low or the store empty, zeroes `fep`, `pfx_flag`, the header log and the prefix log.
- R7: A write whose `unc_status[fep]` is clear, with `mhr_en` high and entries stored, loads the oldest stored entry into the logs and, in the next cycle, drives `status_reassert` with the bits of all entries that were stored before that write, including the one loaded.
- R8: A write that leaves `unc_status[fep]` set with `mhr_en` high drives `status_reassert` with the bits of all stored entries and leaves the logs unchanged.
- R9: A write that leaves `unc_status[fep]` set with `mhr_en` low discards every stored entry.
- R10: `mhr_capable` is high exactly when DEPTH is greater than zero; with DEPTH zero, `mhr_en` has no effect and every record loads directly.
- R11: When a write pops an entry and a record arrives in the same cycle, the popped entry is loaded and the new record is stored behind the remaining entries.
- R12: After reset, `fep`, both logs, `pfx_flag`, `status_reassert` and `log_ovf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rec_valid | input | 1 | Error record strobe |
| rec_status | input | 32 | Status bit(s) of the record |
| rec_hdr_vld | input | 1 | Record carries a valid header |
| rec_pfx_vld | input | 1 | Record carries a prefix |
| rec_hdr | input | 128 | Header words, word i at bits 32i+31:32i |
| rec_pfx | input | 128 | Prefix words, same layout |
| mhr_en | input | 1 | Multiple-header recording enabled |
| pfx_en | input | 1 | End-to-end prefix support enabled |
| sw_wr | input | 1 | Software wrote the uncorrectable status register |
| unc_status | input | 32 | Current uncorrectable status value |
| fep | output | 5 | First-error pointer |
| hdr_log | output | 128 | Header log, byte-reversed words |
| pfx_log | output | 128 | Prefix log, byte-reversed words |
| pfx_flag | output | 1 | Prefix log holds a prefix |
| status_reassert | output | 32 | One-cycle mask of status bits to set again |
| log_ovf | output | 1 | One-cycle pulse: record dropped, store full |
| mhr_capable | output | 1 | Multiple-header recording can be offered |

## Verification
A vector table checks the direct-load path for one status bit at each end of the range, a multi-bit status, a header marked invalid and a prefix with support turned off. These cases separate pointer encoding from byte reversal and from prefix gating. Directed sequences queue two records and then issue a write that keeps the first bit set, followed by successive clears. These show whether the re-assert mask differs between holding and popping, and whether entries come out oldest first. A fill-to-overflow run that is then drained shows that the extra record was really dropped. A flush followed by a clear shows that discarded entries never come back. A simultaneous pop and record checks the ordering, and an instance with no store shows that the recording enable is ignored there.

// File: rtl/hdrq_pkg.sv
`timescale 1ns/1ps
package hdrq_pkg;
   localparam int STAT_W  = 32;
   localparam int WORD_W  = 32;
   localparam int N_WORDS = 4;
   localparam int IDX_W   = $clog2(STAT_W);
   localparam int LOG_W   = WORD_W * N_WORDS;
   localparam int BYTES_W = WORD_W / 8;

   typedef struct packed {
      logic [IDX_W-1:0] idx;
      logic             hdr_vld;
      logic             pfx_vld;
      logic [LOG_W-1:0] hdr;
      logic [LOG_W-1:0] pfx;
   } hdrq_entry_t;

   function automatic logic [IDX_W-1:0] low_bit_idx(input logic [STAT_W-1:0] s);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int b = STAT_W - 1; b >= 0; b--)
         if (s[b]) r = IDX_W'(b);
      return r;
   endfunction

   function automatic logic [LOG_W-1:0] swap_words(input logic [LOG_W-1:0] w);
      logic [LOG_W-1:0] r;
      for (int n = 0; n < N_WORDS; n++)
         for (int k = 0; k < BYTES_W; k++)
            r[n*WORD_W + 8*k +: 8] = w[n*WORD_W + WORD_W - 8 - 8*k +: 8];
      return r;
   endfunction
endpackage

// File: rtl/hdrq_fifo.sv
`timescale 1ns/1ps
module hdrq_fifo
   import hdrq_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              flush,
   input  hdrq_entry_t       wdata,
   output hdrq_entry_t       head,
   output logic              empty,
   output logic              full,
   output logic [STAT_W-1:0] pend_mask
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   hdrq_entry_t      slot [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] tgt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));
   assign head  = slot[0];
   assign tgt   = pop ? cnt - CNT_W'(1) : cnt;

   always_comb begin
      if (flush)            cnt_nxt = '0;
      else if (push && !pop) cnt_nxt = cnt + CNT_W'(1);
      else if (pop && !push) cnt_nxt = cnt - CNT_W'(1);
      else                   cnt_nxt = cnt;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;

   // shift toward the head on pop; the write lands after the shift
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push && CNT_W'(i) == tgt)
            slot[i] <= wdata;
         else if (pop && i < DEPTH - 1)
            slot[i] <= slot[(i < DEPTH - 1) ? i + 1 : i];
      end
   end

   always_comb begin
      pend_mask = '0;
      for (int i = 0; i < DEPTH; i++)
         if (CNT_W'(i) < cnt) pend_mask[slot[i].idx] = 1'b1;
   end
endmodule

// File: rtl/hdrq_log_regs.sv
`timescale 1ns/1ps
module hdrq_log_regs
   import hdrq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             clear,
   input  hdrq_entry_t      entry,
   input  logic             pfx_en,
   output logic [IDX_W-1:0] fep,
   output logic [LOG_W-1:0] hdr_log,
   output logic [LOG_W-1:0] pfx_log,
   output logic             pfx_flag
);
   logic take_pfx;
   assign take_pfx = entry.pfx_vld && pfx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fep      <= '0;
         hdr_log  <= '0;
         pfx_log  <= '0;
         pfx_flag <= 1'b0;
      end else if (load) begin
         fep      <= entry.idx;
         hdr_log  <= entry.hdr_vld ? swap_words(entry.hdr) : '0;
         pfx_log  <= take_pfx ? swap_words(entry.pfx) : '0;
         pfx_flag <= take_pfx;
      end else if (clear) begin
         fep      <= '0;
         hdr_log  <= '0;
         pfx_log  <= '0;
         pfx_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/hdrq_log_queue.sv
`timescale 1ns/1ps
module hdrq_log_queue
   import hdrq_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_valid,
   input  logic [STAT_W-1:0] rec_status,
   input  logic              rec_hdr_vld,
   input  logic              rec_pfx_vld,
   input  logic [LOG_W-1:0]  rec_hdr,
   input  logic [LOG_W-1:0]  rec_pfx,
   input  logic              mhr_en,
   input  logic              pfx_en,
   input  logic              sw_wr,
   input  logic [STAT_W-1:0] unc_status,
   output logic [IDX_W-1:0]  fep,
   output logic [LOG_W-1:0]  hdr_log,
   output logic [LOG_W-1:0]  pfx_log,
   output logic              pfx_flag,
   output logic [STAT_W-1:0] status_reassert,
   output logic              log_ovf,
   output logic              mhr_capable
);
   localparam bit HAS_Q = (DEPTH > 0);

   if (DEPTH < 0 || DEPTH > 64) begin : g_bad_depth
      $error("hdrq_log_queue: DEPTH must lie in 0..64");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("hdrq_log_queue: WORD_W must be whole bytes");
   end

   hdrq_entry_t       rec_entry, q_head, ld_entry;
   logic              q_empty, q_full, q_push, q_pop, q_flush;
   logic [STAT_W-1:0] q_mask;
   logic              mhr_act, first_set, clr_ev, busy, load_rec;

   always_comb begin
      rec_entry.idx     = low_bit_idx(rec_status);
      rec_entry.hdr_vld = rec_hdr_vld;
      rec_entry.pfx_vld = rec_pfx_vld;
      rec_entry.hdr     = rec_hdr;
      rec_entry.pfx     = rec_pfx;
   end

   assign mhr_act   = mhr_en && HAS_Q;
   assign first_set = unc_status[fep];
   assign clr_ev    = sw_wr && !first_set;
   assign q_pop     = clr_ev && mhr_act && !q_empty;
   assign q_flush   = sw_wr && first_set && !mhr_act;
   // log stays owned if its bit is still set or a pop refills it this cycle
   assign busy      = mhr_act && (first_set || q_pop);
   assign q_push    = rec_valid && busy && (!q_full || q_pop);
   assign load_rec  = rec_valid && !busy;
   assign ld_entry  = q_pop ? q_head : rec_entry;

   if (HAS_Q) begin : g_queue
      hdrq_fifo #(.DEPTH(DEPTH)) i_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (q_push),
         .pop       (q_pop),
         .flush     (q_flush),
         .wdata     (rec_entry),
         .head      (q_head),
         .empty     (q_empty),
         .full      (q_full),
         .pend_mask (q_mask)
      );
   end else begin : g_no_queue
      logic unused_q;
      assign unused_q = ^{q_push, q_flush};
      assign q_head   = '0;
      assign q_empty  = 1'b1;
      assign q_full   = 1'b1;
      assign q_mask   = '0;
   end

   hdrq_log_regs i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (q_pop || load_rec),
      .clear    (clr_ev && !q_pop),
      .entry    (ld_entry),
      .pfx_en   (pfx_en),
      .fep      (fep),
      .hdr_log  (hdr_log),
      .pfx_log  (pfx_log),
      .pfx_flag (pfx_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_reassert <= '0;
         log_ovf         <= 1'b0;
      end else begin
         status_reassert <= (sw_wr && mhr_act && (first_set || q_pop)) ? q_mask : '0;
         log_ovf         <= rec_valid && busy && q_full && !q_pop;
      end
   end

   assign mhr_capable = HAS_Q;
endmodule

// File: rtl/hdrq_log_queue_chk.sv
`timescale 1ns/1ps
module hdrq_log_queue_chk
   import hdrq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              rec_valid,
   input logic              sw_wr,
   input logic              mhr_en,
   input logic              pfx_en,
   input logic [STAT_W-1:0] unc_status,
   input logic [IDX_W-1:0]  fep,
   input logic [LOG_W-1:0]  hdr_log,
   input logic [LOG_W-1:0]  pfx_log,
   input logic              pfx_flag,
   input logic [STAT_W-1:0] status_reassert,
   input logic              log_ovf
);
   a_r5_ovf_from_record: assert property (@(posedge clk) disable iff (!rst_n)
      log_ovf |-> $past(rec_valid && mhr_en));

   a_r3_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pfx_flag) |-> $past(pfx_en));

   a_r8_reassert_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|status_reassert) |-> $past(sw_wr && mhr_en));

   a_r6_clear_empties_logs: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_wr && !unc_status[fep] && !mhr_en && !rec_valid)
      |-> (fep == '0 && !pfx_flag && hdr_log == '0 && pfx_log == '0));

   a_r4_log_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rec_valid) && !$past(sw_wr)) |-> ($stable(hdr_log) && $stable(fep)));
endmodule

bind hdrq_log_queue hdrq_log_queue_chk i_chk (.*);

// File: tb/test_hdrq_log_queue.sv
`timescale 1ns/1ps
module test_hdrq_log_queue;
   import hdrq_pkg::*;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rec_valid = 1'b0, rec_hdr_vld = 1'b0, rec_pfx_vld = 1'b0;
   logic [STAT_W-1:0] rec_status = '0;
   logic [LOG_W-1:0]  rec_hdr = '0, rec_pfx = '0;
   logic              mhr_en = 1'b0, pfx_en = 1'b0, sw_wr = 1'b0;
   logic [STAT_W-1:0] unc_status = '0;
   logic [IDX_W-1:0]  fep, z_fep;
   logic [LOG_W-1:0]  hdr_log, pfx_log, z_hdr, z_pfx;
   logic              pfx_flag, log_ovf, mhr_capable, z_flag, z_ovf, z_cap;
   logic [STAT_W-1:0] status_reassert, z_reassert;

   int vectors = 0;
   int miscompares = 0;

   always #5 clk = ~clk;

   hdrq_log_queue #(.DEPTH(8)) i_hdrq_log_queue (
      .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
      .rec_hdr_vld(rec_hdr_vld), .rec_pfx_vld(rec_pfx_vld), .rec_hdr(rec_hdr),
      .rec_pfx(rec_pfx), .mhr_en(mhr_en), .pfx_en(pfx_en), .sw_wr(sw_wr),
      .unc_status(unc_status), .fep(fep), .hdr_log(hdr_log), .pfx_log(pfx_log),
      .pfx_flag(pfx_flag), .status_reassert(status_reassert), .log_ovf(log_ovf),
      .mhr_capable(mhr_capable));

   // no-store variant: recording enable held high, every status bit set
   hdrq_log_queue #(.DEPTH(0)) i_hdrq_log_queue_z (
      .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
      .rec_hdr_vld(rec_hdr_vld), .rec_pfx_vld(rec_pfx_vld), .rec_hdr(rec_hdr),
      .rec_pfx(rec_pfx), .mhr_en(1'b1), .pfx_en(pfx_en), .sw_wr(1'b0),
      .unc_status({STAT_W{1'b1}}), .fep(z_fep), .hdr_log(z_hdr), .pfx_log(z_pfx),
      .pfx_flag(z_flag), .status_reassert(z_reassert), .log_ovf(z_ovf),
      .mhr_capable(z_cap));

   typedef struct packed {
      logic [31:0] status;
      logic        hv;
      logic        pv;
      logic        pe;
      logic [4:0]  efep;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{32'h0000_0010, 1'b1, 1'b1, 1'b1, 5'd4},
      '{32'h8000_0000, 1'b1, 1'b0, 1'b1, 5'd31},
      '{32'h0000_0006, 1'b0, 1'b1, 1'b1, 5'd1},
      '{32'h0000_0001, 1'b1, 1'b1, 1'b0, 5'd0},
      '{32'h0010_0000, 1'b1, 1'b0, 1'b0, 5'd20}
   };

   function automatic logic [127:0] hdr_of(input int k);
      logic [127:0] r;
      for (int w = 0; w < 4; w++)
         r[32*w +: 32] = 32'h1122_3344 + 32'(k) * 32'h0103_0507 + 32'(w) * 32'h0010_2000;
      return r;
   endfunction

   function automatic logic [127:0] pfx_of(input int k);
      return ~hdr_of(k) ^ {4{32'h00FF_0F0F}};
   endfunction

   function automatic logic [127:0] rev(input logic [127:0] x);
      logic [127:0] r;
      for (int w = 0; w < 4; w++)
         r[32*w +: 32] = {x[32*w +: 8], x[32*w+8 +: 8], x[32*w+16 +: 8], x[32*w+24 +: 8]};
      return r;
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_rec(input int bitn, input int k, input logic hv, input logic pv);
      rec_status  = 32'h1 << bitn;
      rec_hdr     = hdr_of(k);
      rec_pfx     = pfx_of(k);
      rec_hdr_vld = hv;
      rec_pfx_vld = pv;
      rec_valid   = 1'b1;
      @(negedge clk);
      rec_valid   = 1'b0;
   endtask

   task automatic do_write(input logic [31:0] val);
      unc_status = val;
      sw_wr      = 1'b1;
      @(negedge clk);
      sw_wr      = 1'b0;
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 fep", 128'(fep), 0);
      chk("R12 hdr", hdr_log, 0);
      chk("R12 pfx", {pfx_log[126:0], pfx_flag}, 0);
      chk("R12 reassert/ovf", {status_reassert, log_ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 capable", {mhr_capable, z_cap}, 2'b10);

      // table walk: direct loads, R1 R2 R3
      for (int v = 0; v < 5; v++) begin
         int b;
         b = 0;
         for (int j = 31; j >= 0; j--) if (VECS[v].status[j]) b = j;
         pfx_en      = VECS[v].pe;
         rec_status  = VECS[v].status;
         rec_hdr     = hdr_of(v);
         rec_pfx     = pfx_of(v);
         rec_hdr_vld = VECS[v].hv;
         rec_pfx_vld = VECS[v].pv;
         rec_valid   = 1'b1;
         @(negedge clk);
         rec_valid   = 1'b0;
         chk("R1 fep", 128'(fep), 128'(VECS[v].efep));
         chk("R2 header", hdr_log, VECS[v].hv ? rev(hdr_of(v)) : 128'h0);
         chk("R3 prefix", pfx_log, (VECS[v].pv && VECS[v].pe) ? rev(pfx_of(v)) : 128'h0);
         chk("R3 flag", 128'(pfx_flag), 128'(VECS[v].pv && VECS[v].pe));
         if (b != int'(VECS[v].efep)) $display("table entry %0d inconsistent", v);
      end

      // queueing, hold-write re-assert, pops in order
      mhr_en = 1'b1; pfx_en = 1'b1; unc_status = '0;
      send_rec(3, 10, 1'b1, 1'b1);
      chk("R1 fep A", 128'(fep), 3);
      unc_status = 32'h0000_0008;
      send_rec(5, 11, 1'b1, 1'b0);
      chk("R4 fep held", 128'(fep), 3);
      chk("R4 header held", hdr_log, rev(hdr_of(10)));
      unc_status = 32'h0000_0028;
      send_rec(7, 12, 1'b1, 1'b1);
      do_write(32'h0000_00A8);
      chk("R8 reassert", 128'(status_reassert), 128'h0A0);
      chk("R8 fep held", 128'(fep), 3);
      do_write(32'h0000_00A0);
      chk("R7 reassert", 128'(status_reassert), 128'h0A0);
      chk("R7 fep oldest", 128'(fep), 5);
      chk("R7 header oldest", hdr_log, rev(hdr_of(11)));
      chk("R7 prefix cleared", {pfx_log[126:0], pfx_flag}, 0);
      do_write(32'h0000_0080);
      chk("R7 reassert last", 128'(status_reassert), 128'h080);
      chk("R7 header next", hdr_log, rev(hdr_of(12)));
      do_write(32'h0);
      chk("R6 fep cleared", 128'(fep), 0);
      chk("R6 logs cleared", hdr_log | pfx_log, 0);
      chk("R6 no reassert", 128'(status_reassert), 0);

      // overflow: one logged, eight stored, ninth dropped
      send_rec(9, 40, 1'b1, 1'b0);
      unc_status = 32'h0000_0200;
      for (int j = 0; j < 8; j++) begin
         send_rec(10 + j, 41 + j, 1'b1, 1'b0);
         unc_status[10 + j] = 1'b1;
      end
      chk("R5 no ovf at fill", 128'(log_ovf), 0);
      send_rec(18, 60, 1'b1, 1'b0);
      chk("R5 ovf pulse", 128'(log_ovf), 1);
      @(negedge clk);
      chk("R5 ovf one cycle", 128'(log_ovf), 0);
      for (int j = 0; j < 8; j++) begin
         unc_status[9 + j] = 1'b0;
         do_write(unc_status);
         chk("R5 drain order", 128'(fep), 128'(10 + j));
      end
      do_write(32'h0);
      chk("R5 dropped record absent", 128'(fep), 0);

      // flush with recording disabled
      send_rec(2, 20, 1'b1, 1'b0);
      unc_status = 32'h0000_0004;
      send_rec(4, 21, 1'b1, 1'b0);
      mhr_en = 1'b0;
      do_write(32'h0000_0014);
      chk("R9 log kept", 128'(fep), 2);
      mhr_en = 1'b1;
      do_write(32'h0000_0010);
      chk("R9 queue discarded", 128'(fep), 0);
      chk("R9 header zero", hdr_log, 0);
      chk("R9 no reassert", 128'(status_reassert), 0);

      // pop and record in the same cycle
      unc_status = '0;
      send_rec(2, 30, 1'b1, 1'b0);
      unc_status = 32'h0000_0004;
      send_rec(4, 31, 1'b1, 1'b0);
      unc_status  = 32'h0000_0010;
      rec_status  = 32'h0000_0040;
      rec_hdr     = hdr_of(32);
      rec_hdr_vld = 1'b1;
      rec_pfx_vld = 1'b0;
      rec_valid   = 1'b1;
      sw_wr       = 1'b1;
      @(negedge clk);
      rec_valid = 1'b0; sw_wr = 1'b0;
      chk("R11 popped loaded", 128'(fep), 4);
      chk("R11 popped header", hdr_log, rev(hdr_of(31)));
      do_write(32'h0000_0040);
      chk("R11 record queued behind", 128'(fep), 6);
      chk("R11 record header", hdr_log, rev(hdr_of(32)));
      chk("R10 no-store loads directly", 128'(z_fep), 6);
      chk("R10 no-store no ovf", 128'(z_ovf), 0);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule